// File: doc/BRIEF.md
# Dual-Channel Asymmetric Address Mapper

This block turns a flat physical request address into a physical channel choice and an address local to that channel, for a memory system with two channels that may hold different amounts of memory. The low part of the address space is spread over both channels one 64-byte line at a time. Line bit 6 picks the channel, so neighbouring lines always land on different channels. The low part reaches up to twice the smaller channel's capacity. Everything above it goes to the larger channel alone. When only one channel is populated, every legal address goes to that channel. When both channels hold the same amount, the whole space is interleaved. An address at or beyond the total installed capacity is flagged and selects no channel.

Configuration is static in normal use. It is loaded from the `cfg_*` inputs only in a cycle where `cfg_valid` is high. The capacities are given for a logical channel A, which is the larger or equal one, and a logical channel B. `cfg_a_phys` says which physical channel plays A. The configuration register is a small mode state machine with four states. `MODE_UNCFG` (encoding 0) means nothing is installed. `MODE_SINGLE` (1) means only A holds memory. `MODE_SPLIT` (2) means A holds more than B. `MODE_EVEN` (3) means A and B hold the same amount. There is one transition, LOAD. It is taken from any state when `cfg_valid` is high, and it classifies the new capacities. With `cfg_valid` low the state holds. Requests are decoded combinationally and registered once, so results appear one cycle after `req_valid`.

Top module: `dual_chan_addr_mapper`

## Requirements
- R1: After reset, `out_valid` is 0, `out_chan_sel` is 00 and `map_mode` is 0 (`MODE_UNCFG`). While unconfigured, every request returns `out_oor`=1 with no channel selected.
- R2: Each cycle with `req_valid` high yields exactly one result with `out_valid` high on the following cycle, in request order.
- R3: In split or even mode, an address below 2*cap_b is interleaved. Address bit 6 = 0 selects A and bit 6 = 1 selects B. The local address is the request address with bit 6 removed: bits above 6 shift down one place and bits 5:0 are kept.
- R4: In split mode, an address from 2*cap_b up to cap_a+cap_b-1 selects A, with local address = request address - cap_b.
- R5: With cap_a equal to cap_b (non-zero), the mode is `MODE_EVEN` (3) and every address below the total is interleaved as in R3.
- R6: With cap_b = 0 and cap_a > 0, the mode is `MODE_SINGLE` (1) and every address below cap_a selects A with local address equal to the request address.
- R7: An address at or above cap_a+cap_b sets `out_oor`=1, with `out_chan_sel`=00 and `out_local`=0.
- R8: `out_chan_sel` is one-hot on a legal address. Bit 0 means physical channel 0 and bit 1 means physical channel 1. Logical A is physical channel `cfg_a_phys` and B is the other.
- R9: Configuration inputs take effect only in a cycle with `cfg_valid` high. Changes to them while `cfg_valid` is low alter neither `map_mode` nor any mapping result.
- R10: Unequal non-zero capacities give `MODE_SPLIT` (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Load strobe for the configuration inputs |
| cfg_cap_a | input | ADDR_W | Capacity in bytes of logical channel A (the larger) |
| cfg_cap_b | input | ADDR_W | Capacity in bytes of logical channel B |
| cfg_a_phys | input | 1 | Physical channel that serves as A |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Flat request address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_chan_sel | output | 2 | One-hot physical channel select |
| out_local | output | ADDR_W | Channel-local address |
| out_oor | output | 1 | Address beyond installed capacity |
| map_mode | output | 2 | Current mode state |

## Verification
The assertions assume that `cfg_cap_a` is never below `cfg_cap_b`, and that both capacities are multiples of 128 bytes. Under that assumption every local address they check fits inside the selected channel. The local-range and single-mode checks only apply to a result whose request cycle had `cfg_valid` low, because a load in that same cycle changes the registers the check compares against. The stimulus loads only ordered, 128-byte-aligned capacities. It sends no request in a cycle that loads configuration. It covers the interleave edges, the first upper-zone line, the last legal byte, the first illegal byte and the physical swap.

// File: rtl/amap_pkg.sv
package amap_pkg;
    typedef enum logic [1:0] {
        MODE_UNCFG  = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_SPLIT  = 2'd2,
        MODE_EVEN   = 2'd3
    } map_mode_e;
endpackage

// File: rtl/amap_cfg_fsm.sv
module amap_cfg_fsm
    import amap_pkg::*;
#(
    parameter int ADDR_W = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_cap_a,
    input  logic [ADDR_W-1:0] cfg_cap_b,
    input  logic              cfg_a_phys,
    output map_mode_e         mode,
    output logic [ADDR_W-1:0] cap_a,
    output logic [ADDR_W-1:0] cap_b,
    output logic              a_phys
);
    map_mode_e state_q, state_d;

    // LOAD transition: classify the offered capacities
    always_comb begin
        state_d = state_q;
        if (cfg_valid) begin
            if (cfg_cap_a == '0)
                state_d = MODE_UNCFG;
            else if (cfg_cap_b == '0)
                state_d = MODE_SINGLE;
            else if (cfg_cap_a == cfg_cap_b)
                state_d = MODE_EVEN;
            else
                state_d = MODE_SPLIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_UNCFG;
            cap_a   <= '0;
            cap_b   <= '0;
            a_phys  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_valid) begin
                cap_a  <= cfg_cap_a;
                cap_b  <= cfg_cap_b;
                a_phys <= cfg_a_phys;
            end
        end
    end

    assign mode = state_q;

    // R9: mode holds without a load strobe
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |=> $stable(state_q));
    // R9: stored capacities hold without a load strobe
    a_r9_cap_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |=> ($stable(cap_a) && $stable(cap_b) && $stable(a_phys)));
endmodule

// File: rtl/amap_decode.sv
module amap_decode
    import amap_pkg::*;
#(
    parameter int ADDR_W    = 34,
    parameter int LINE_LOG2 = 6
) (
    input  map_mode_e         mode,
    input  logic [ADDR_W-1:0] cap_a,
    input  logic [ADDR_W-1:0] cap_b,
    input  logic              a_phys,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        chan_sel,
    output logic [ADDR_W-1:0] local_addr,
    output logic              oor
);
    localparam int TOT_W = ADDR_W + 1;

    logic [TOT_W-1:0]  total;
    logic [TOT_W-1:0]  il_top;
    logic [TOT_W-1:0]  addr_x;
    logic [ADDR_W-1:0] il_local;
    logic              pick_b;
    logic              phys;

    assign total    = {1'b0, cap_a} + {1'b0, cap_b};
    assign il_top   = {cap_b, 1'b0};
    assign addr_x   = {1'b0, addr};
    assign il_local = {1'b0, addr[ADDR_W-1:LINE_LOG2+1], addr[LINE_LOG2-1:0]};

    always_comb begin
        oor        = (addr_x >= total);
        pick_b     = 1'b0;
        local_addr = addr;
        unique case (mode)
            MODE_UNCFG: begin
                oor = 1'b1;
            end
            MODE_SINGLE: begin
                pick_b     = 1'b0;
                local_addr = addr;
            end
            MODE_SPLIT: begin
                if (addr_x < il_top) begin
                    pick_b     = addr[LINE_LOG2];
                    local_addr = il_local;
                end else begin
                    pick_b     = 1'b0;
                    local_addr = addr - cap_b;
                end
            end
            MODE_EVEN: begin
                pick_b     = addr[LINE_LOG2];
                local_addr = il_local;
            end
            default: oor = 1'b1;
        endcase
        phys = pick_b ? ~a_phys : a_phys;
        if (oor) begin
            chan_sel   = 2'b00;
            local_addr = '0;
        end else begin
            chan_sel = phys ? 2'b10 : 2'b01;
        end
    end
endmodule

// File: rtl/amap_out_stage.sv
module amap_out_stage #(
    parameter int ADDR_W = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_sel,
    input  logic [ADDR_W-1:0] in_local,
    input  logic              in_oor,
    output logic              out_valid,
    output logic [1:0]        out_sel,
    output logic [ADDR_W-1:0] out_local,
    output logic              out_oor
);
    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_valid <= 1'b0;
            out_sel   <= 2'b00;
            out_local <= '0;
            out_oor   <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            out_sel   <= in_sel;
            out_local <= in_local;
            out_oor   <= in_oor;
        end
    end

    // R2: one result per request, one cycle later
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R7: out of range selects no channel
    a_r7_oor_no_sel: assert property (@(posedge clk) disable iff (rst)
        out_oor |-> (out_sel == 2'b00 && out_local == '0));
    // R8: legal result is one-hot
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_oor) |-> ($countones(out_sel) == 1));
endmodule

// File: rtl/dual_chan_addr_mapper.sv
module dual_chan_addr_mapper
    import amap_pkg::*;
#(
    parameter int ADDR_W    = 34,
    parameter int LINE_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_cap_a,
    input  logic [ADDR_W-1:0] cfg_cap_b,
    input  logic              cfg_a_phys,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic [1:0]        out_chan_sel,
    output logic [ADDR_W-1:0] out_local,
    output logic              out_oor,
    output logic [1:0]        map_mode
);
    map_mode_e         mode;
    logic [ADDR_W-1:0] cap_a, cap_b;
    logic              a_phys;
    logic [1:0]        dec_sel;
    logic [ADDR_W-1:0] dec_local;
    logic              dec_oor;

    amap_cfg_fsm #(.ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid),
        .cfg_cap_a(cfg_cap_a), .cfg_cap_b(cfg_cap_b), .cfg_a_phys(cfg_a_phys),
        .mode(mode), .cap_a(cap_a), .cap_b(cap_b), .a_phys(a_phys)
    );

    amap_decode #(.ADDR_W(ADDR_W), .LINE_LOG2(LINE_LOG2)) u_dec (
        .mode(mode), .cap_a(cap_a), .cap_b(cap_b), .a_phys(a_phys),
        .addr(req_addr), .chan_sel(dec_sel), .local_addr(dec_local), .oor(dec_oor)
    );

    amap_out_stage #(.ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst(rst), .in_valid(req_valid),
        .in_sel(dec_sel), .in_local(dec_local), .in_oor(dec_oor),
        .out_valid(out_valid), .out_sel(out_chan_sel),
        .out_local(out_local), .out_oor(out_oor)
    );

    assign map_mode = mode;

    logic [ADDR_W-1:0] sel_cap;
    assign sel_cap = (out_chan_sel[1] == a_phys) ? cap_a : cap_b;

    // R3/R4: local address stays inside the selected channel
    a_r4_local_fits: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_oor && !$past(cfg_valid)) |-> (out_local < sel_cap));
    // R6: single mode always picks physical A
    a_r6_single_a: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_oor && !$past(cfg_valid) && mode == MODE_SINGLE)
        |-> (out_chan_sel == (a_phys ? 2'b10 : 2'b01)));
    // R1: unconfigured requests are out of range
    a_r1_uncfg_oor: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(cfg_valid) && mode == MODE_UNCFG) |-> out_oor);
endmodule

// File: tb/dual_chan_addr_mapper_bench.sv
module dual_chan_addr_mapper_bench;
    localparam int ADDR_W = 34;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_valid = 1'b0;
    logic [ADDR_W-1:0] cfg_cap_a = '0;
    logic [ADDR_W-1:0] cfg_cap_b = '0;
    logic              cfg_a_phys = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              out_valid;
    logic [1:0]        out_chan_sel;
    logic [ADDR_W-1:0] out_local;
    logic              out_oor;
    logic [1:0]        map_mode;

    dual_chan_addr_mapper #(.ADDR_W(ADDR_W)) u_dual_chan_addr_mapper (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid),
        .cfg_cap_a(cfg_cap_a), .cfg_cap_b(cfg_cap_b), .cfg_a_phys(cfg_a_phys),
        .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_chan_sel(out_chan_sel),
        .out_local(out_local), .out_oor(out_oor), .map_mode(map_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        oor;
        logic [1:0]  sel;
        logic [63:0] loc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] m_cap_a = 0, m_cap_b = 0;
    logic        m_a_phys = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [63:0] a, input string tag);
        exp_t r;
        logic [63:0] total;
        logic lb, ph;
        r.oor = 0; r.sel = 2'b00; r.loc = 0; r.tag = tag;
        total = m_cap_a + m_cap_b;
        if (m_cap_a == 0 || a >= total) begin
            r.oor = 1;
        end else begin
            if (a < 2 * m_cap_b) begin
                lb = a[6];
                r.loc = (a / 128) * 64 + (a % 64);
            end else begin
                lb = 0;
                r.loc = a - m_cap_b;
            end
            ph = lb ? !m_a_phys : m_a_phys;
            r.sel = ph ? 2'b10 : 2'b01;
        end
        return r;
    endfunction

    task automatic send(input logic [63:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a[ADDR_W-1:0];
        q.push_back(model(a, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic load_cfg(input logic [63:0] ca, input logic [63:0] cb, input logic ph,
                            input logic [1:0] exp_mode, input string tag);
        idle(2);
        cfg_valid  = 1'b1;
        cfg_cap_a  = ca[ADDR_W-1:0];
        cfg_cap_b  = cb[ADDR_W-1:0];
        cfg_a_phys = ph;
        m_cap_a = ca; m_cap_b = cb; m_a_phys = ph;
        @(negedge clk);
        cfg_valid = 1'b0;
        check(map_mode == exp_mode, tag, map_mode, exp_mode);
    endtask

    // monitor: compare each result against the queue front
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (q.size() == 0) begin
                    check(0, "R2 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_oor == e.oor && out_chan_sel == e.sel && out_local == e.loc[ADDR_W-1:0],
                          e.tag, {out_oor, out_chan_sel, 1'b0, 28'h0, out_local},
                          {e.oor, e.sel, 1'b0, 28'h0, e.loc[ADDR_W-1:0]});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_valid == 0 && out_chan_sel == 0 && map_mode == 0, "R1 reset",
              {out_valid, out_chan_sel, map_mode}, 0);
        send(64'h0, "R1 unconfigured");
        send(64'h40, "R1 unconfigured");

        // split: A=4096, B=1024, A is physical 0
        load_cfg(4096, 1024, 1'b0, 2'd2, "R10 split mode");
        send(64'h0,   "R3 line0 to A");
        send(64'h40,  "R3 line1 to B");
        send(64'h80,  "R3 line2 to A");
        send(64'h7C5, "R3 last interleaved line");
        send(64'h800, "R4 first upper");
        send(64'h13FF, "R4 last legal byte");
        send(64'h1400, "R7 first illegal");
        send(64'h3FFFFFFFF, "R7 top address");

        // R9: inputs change without strobe; old mapping must persist
        idle(1);
        cfg_cap_a = 34'd2048; cfg_cap_b = 34'd2048; cfg_a_phys = 1'b1;
        send(64'h800, "R9 ignored cfg upper");
        send(64'h40,  "R9 ignored cfg interleave");
        idle(2);
        check(map_mode == 2'd2, "R9 mode held", map_mode, 2);

        // swap: A is physical 1
        load_cfg(4096, 1024, 1'b1, 2'd2, "R10 split swapped");
        send(64'h0,  "R8 A on phys1");
        send(64'h40, "R8 B on phys0");
        send(64'hC00, "R8 upper on phys1");

        // even
        load_cfg(2048, 2048, 1'b0, 2'd3, "R5 even mode");
        send(64'hFFF, "R5 top interleaved B");
        send(64'hF80, "R5 top interleaved A");
        send(64'h1000, "R7 even beyond");

        // single
        load_cfg(8192, 0, 1'b1, 2'd1, "R6 single mode");
        send(64'h40,  "R6 line1 stays A");
        send(64'h1FFF, "R6 last byte");
        send(64'h2000, "R7 single beyond");

        // large capacities near the address top
        load_cfg(64'h200000000, 64'h100000000, 1'b0, 2'd2, "R10 large split");
        send(64'h1FFFFFFC0, "R3 large interleave");
        send(64'h200000005, "R4 large upper");
        send(64'h2FFFFFFFF, "R4 large last");
        send(64'h300000000, "R7 large beyond");

        // back to unconfigured
        load_cfg(0, 0, 1'b0, 2'd0, "R1 unconfigured reload");
        send(64'h0, "R1 reload oor");

        idle(4);
        check(q.size() == 0, "R2 all results seen", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule